// File: doc/BRIEF.md
# Addressable RGB Pixel Line Encoder

This block turns a stream of 24-bit colour words into the single-wire pulse train that chained addressable RGB LEDs expect. Every data bit goes out as a high pulse followed by a low pulse. Four pulse lengths, counted in module-clock cycles, are programmable: the high and low times of a one bit and of a zero bit. A programmable colour-order mode picks which channel of each pixel goes first on the wire. After the last pixel the line stays low for a programmable latch gap, and then the block reports the frame done.

A frame starts from a start pulse that carries a pixel count. The encoder pulls pixels over a valid/ready handshake, one per 24 bits. If a pixel is late when the next bit is due, the encoder holds the line low and sets a sticky underrun flag. It does not send a broken bit. The timing, gap and mode inputs are sampled when the frame starts.

The controller is a state machine with seven states. Idle waits for a start. Load waits for the first pixel of a frame. High and Low time the two halves of each bit. Stall waits for a late pixel. Gap times the latch gap. Done lasts one cycle and carries the frame-done pulse. The transitions are as follows:
- Idle goes to Load on an accepted start.
- Load goes to High, and Stall goes to High, when a pixel is taken.
- High goes to Low when the high time expires.
- Low goes to High for the next bit of the same pixel.
- Low goes to High when the next pixel is taken at the bit boundary.
- Low goes to Stall when that pixel is missing.
- Low goes to Gap after the last bit of the frame.
- Gap goes to Done when the gap expires.
- Done goes back to Idle.

Top module: `pixel_line_encoder`

## Requirements
- R1: After reset, `line_out`, `busy`, `pix_ready`, `frame_done` and `underrun` are all low, and the line stays low while idle.
- R2: A start is taken only when the block is idle and `frame_len` is nonzero. A start with zero length is ignored and leaves `busy` low. A start while busy is ignored, and the running frame keeps its own length.
- R3: A pixel word holds red in bits 23:16, green in 15:8 and blue in 7:0. `color_mode` selects the order of the channels on the wire: 0=R,G,B; 1=R,B,G; 2=G,R,B; 3=G,B,R; 4=B,R,G; 5=B,G,R. Codes 6 and 7 act as 2. Each channel is sent MSB first.
- R4: A one bit is high for the count in `bit_timing[26:21]` and then low for the count in `bit_timing[20:16]`. A zero bit is high for the count in `bit_timing[10:6]` and then low for the count in `bit_timing[5:0]`.
- R5: A programmed pulse count or gap count of zero gives one cycle.
- R6: After the low half of the last bit, the line stays low for `latch_gap` cycles. `frame_done` is then high for exactly one cycle, with the line low, and `busy` falls in the next cycle.
- R7: The frame sends min(`frame_len`, MAX_PIX) pixels, and exactly that many handshakes are accepted.
- R8: If the next pixel is not valid when the last bit of a pixel ends, the line stays low and `underrun` is set. The late pixel is still sent intact. `underrun` holds until the next accepted start clears it.
- R9: Timing, gap and mode are captured at the accepted start. Changes to them during a frame have no effect on that frame.
- R10: `pix_ready` is high only while busy and waiting for a pixel. A pixel is taken on a cycle where `pix_valid` and `pix_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock; all pulse counts are in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a frame |
| frame_len | input | 13 | Pixels in the frame |
| bit_timing | input | 32 | One-high 26:21, one-low 20:16, zero-high 10:6, zero-low 5:0 |
| latch_gap | input | 20 | Low cycles after the last bit |
| color_mode | input | 3 | Channel order selector |
| pix_valid | input | 1 | Pixel word offered |
| pix_data | input | 24 | Pixel word, R 23:16, G 15:8, B 7:0 |
| pix_ready | output | 1 | Encoder takes the offered pixel |
| line_out | output | 1 | Serial data line to the LED chain |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| underrun | output | 1 | Sticky flag for a late pixel |

## Verification
The line output and the handshake are decoded combinationally from the registered state. So a start sampled on one edge shows on `busy` and `pix_ready` one cycle later. A pulse of N counts holds `line_out` for exactly N cycles. The `frame_done` cycle follows the last gap cycle directly. The bench samples every output at the falling edge and measures each high and low run in whole cycles. It ends the last low run at the cycle where `frame_done` is seen, so that run must equal the low count of the last bit plus the gap. Every pulse width therefore follows from the programmed counts with no timing slack.

// File: rtl/ple_pkg.sv
package ple_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_HIGH,
        S_LOW,
        S_STALL,
        S_GAP,
        S_DONE
    } ple_state_t;

    // Field positions inside the bit timing word
    localparam int ONE_HI_LSB  = 21;
    localparam int ONE_HI_W    = 6;
    localparam int ONE_LO_LSB  = 16;
    localparam int ONE_LO_W    = 5;
    localparam int ZERO_HI_LSB = 6;
    localparam int ZERO_HI_W   = 5;
    localparam int ZERO_LO_LSB = 0;
    localparam int ZERO_LO_W   = 6;

    // Channel order codes
    localparam logic [2:0] ORD_RGB = 3'd0;
    localparam logic [2:0] ORD_RBG = 3'd1;
    localparam logic [2:0] ORD_GRB = 3'd2;
    localparam logic [2:0] ORD_GBR = 3'd3;
    localparam logic [2:0] ORD_BRG = 3'd4;
    localparam logic [2:0] ORD_BGR = 3'd5;

endpackage

// File: rtl/ple_color_order.sv
module ple_color_order #(
    parameter int CH_W = 8
) (
    input  logic [2:0]        mode,
    input  logic [3*CH_W-1:0] pix_in,
    output logic [3*CH_W-1:0] wire_word
);
    import ple_pkg::*;

    logic [CH_W-1:0] red, grn, blu;

    assign red = pix_in[3*CH_W-1:2*CH_W];
    assign grn = pix_in[2*CH_W-1:CH_W];
    assign blu = pix_in[CH_W-1:0];

    always_comb begin
        unique case (mode)
            ORD_RGB: wire_word = {red, grn, blu};
            ORD_RBG: wire_word = {red, blu, grn};
            ORD_GRB: wire_word = {grn, red, blu};
            ORD_GBR: wire_word = {grn, blu, red};
            ORD_BRG: wire_word = {blu, red, grn};
            ORD_BGR: wire_word = {blu, grn, red};
            default: wire_word = {grn, red, blu};
        endcase
    end
endmodule

// File: rtl/ple_pulse_timer.sv
module ple_pulse_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/ple_bit_shifter.sv
module ple_bit_shifter #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [WORD_W-1:0] word_in,
    output logic              cur_bit,
    output logic              nxt_bit,
    output logic              last_bit
);
    localparam int IDX_W = $clog2(WORD_W);

    logic [WORD_W-1:0] sreg;
    logic [IDX_W-1:0]  left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            left <= '0;
        end else if (load) begin
            sreg <= word_in;
            left <= IDX_W'(WORD_W - 1);
        end else if (advance) begin
            sreg <= {sreg[WORD_W-2:0], 1'b0};
            left <= left - 1'b1;
        end
    end

    assign cur_bit  = sreg[WORD_W-1];
    assign nxt_bit  = sreg[WORD_W-2];
    assign last_bit = (left == '0);
endmodule

// File: rtl/pixel_line_encoder.sv
module pixel_line_encoder #(
    parameter int MAX_PIX = 1024,
    parameter int LEN_W   = 13,
    parameter int GAP_W   = 20,
    parameter int CH_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [31:0]      bit_timing,
    input  logic [GAP_W-1:0] latch_gap,
    input  logic [2:0]       color_mode,
    input  logic             pix_valid,
    input  logic [3*CH_W-1:0] pix_data,
    output logic             pix_ready,
    output logic             line_out,
    output logic             busy,
    output logic             frame_done,
    output logic             underrun
);
    import ple_pkg::*;

    localparam int WORD_W = 3 * CH_W;
    localparam int CNT_W  = $clog2(MAX_PIX + 1);
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_PIX);

    ple_state_t state_q, state_d;

    logic [ONE_HI_W-1:0]  one_hi_q;
    logic [ONE_LO_W-1:0]  one_lo_q;
    logic [ZERO_HI_W-1:0] zero_hi_q;
    logic [ZERO_LO_W-1:0] zero_lo_q;
    logic [GAP_W-1:0]     gap_q;
    logic [2:0]           mode_q;
    logic [CNT_W-1:0]     pix_left_q;
    logic                 underrun_q;

    logic              start_ok;
    logic              take_pix;
    logic              more_pix;
    logic              t_load;
    logic [GAP_W-1:0]  t_val;
    logic              t_expired;
    logic              sh_load, sh_adv;
    logic              cur_bit, nxt_bit, last_bit;
    logic [WORD_W-1:0] ordered;
    logic              set_underrun;

    // A zero count still yields one cycle: load N-1, saturating at zero
    function automatic logic [GAP_W-1:0] minus_one(input logic [GAP_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    function automatic logic [GAP_W-1:0] high_len(input logic b);
        return b ? GAP_W'(one_hi_q) : GAP_W'(zero_hi_q);
    endfunction

    function automatic logic [GAP_W-1:0] low_len(input logic b);
        return b ? GAP_W'(one_lo_q) : GAP_W'(zero_lo_q);
    endfunction

    ple_color_order #(.CH_W(CH_W)) u_order (
        .mode      (mode_q),
        .pix_in    (pix_data),
        .wire_word (ordered)
    );

    ple_pulse_timer #(.CNT_W(GAP_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    ple_bit_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .advance  (sh_adv),
        .word_in  (ordered),
        .cur_bit  (cur_bit),
        .nxt_bit  (nxt_bit),
        .last_bit (last_bit)
    );

    assign start_ok = (state_q == S_IDLE) && start && (frame_len != '0);
    assign more_pix = (pix_left_q != '0);
    assign take_pix = pix_ready && pix_valid;

    // Next state and datapath controls
    always_comb begin
        state_d      = state_q;
        t_load       = 1'b0;
        t_val        = '0;
        sh_load      = 1'b0;
        sh_adv       = 1'b0;
        set_underrun = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_ok) state_d = S_LOAD;
            end
            S_LOAD, S_STALL: begin
                if (pix_valid) begin
                    state_d = S_HIGH;
                    sh_load = 1'b1;
                    t_load  = 1'b1;
                    t_val   = minus_one(high_len(ordered[WORD_W-1]));
                end
            end
            S_HIGH: begin
                if (t_expired) begin
                    state_d = S_LOW;
                    t_load  = 1'b1;
                    t_val   = minus_one(low_len(cur_bit));
                end
            end
            S_LOW: begin
                if (t_expired) begin
                    if (!last_bit) begin
                        state_d = S_HIGH;
                        sh_adv  = 1'b1;
                        t_load  = 1'b1;
                        t_val   = minus_one(high_len(nxt_bit));
                    end else if (more_pix) begin
                        if (pix_valid) begin
                            state_d = S_HIGH;
                            sh_load = 1'b1;
                            t_load  = 1'b1;
                            t_val   = minus_one(high_len(ordered[WORD_W-1]));
                        end else begin
                            state_d      = S_STALL;
                            set_underrun = 1'b1;
                        end
                    end else begin
                        state_d = S_GAP;
                        t_load  = 1'b1;
                        t_val   = minus_one(gap_q);
                    end
                end
            end
            S_GAP: begin
                if (t_expired) state_d = S_DONE;
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register and captured frame context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            one_hi_q   <= '0;
            one_lo_q   <= '0;
            zero_hi_q  <= '0;
            zero_lo_q  <= '0;
            gap_q      <= '0;
            mode_q     <= ORD_GRB;
            pix_left_q <= '0;
            underrun_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_ok) begin
                one_hi_q   <= bit_timing[ONE_HI_LSB  +: ONE_HI_W];
                one_lo_q   <= bit_timing[ONE_LO_LSB  +: ONE_LO_W];
                zero_hi_q  <= bit_timing[ZERO_HI_LSB +: ZERO_HI_W];
                zero_lo_q  <= bit_timing[ZERO_LO_LSB +: ZERO_LO_W];
                gap_q      <= latch_gap;
                mode_q     <= color_mode;
                pix_left_q <= (frame_len > LEN_CAP) ? CNT_W'(MAX_PIX)
                                                    : CNT_W'(frame_len);
                underrun_q <= 1'b0;
            end else begin
                if (take_pix) pix_left_q <= pix_left_q - 1'b1;
                if (set_underrun) underrun_q <= 1'b1;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        line_out   = 1'b0;
        busy       = 1'b1;
        frame_done = 1'b0;
        pix_ready  = 1'b0;
        unique case (state_q)
            S_IDLE:  busy = 1'b0;
            S_LOAD:  pix_ready = 1'b1;
            S_HIGH:  line_out = 1'b1;
            S_LOW:   pix_ready = t_expired && last_bit && more_pix;
            S_STALL: pix_ready = 1'b1;
            S_GAP:   line_out = 1'b0;
            S_DONE:  frame_done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    assign underrun = underrun_q;
endmodule

// File: rtl/ple_checker.sv
module ple_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [12:0] frame_len,
    input logic        pix_ready,
    input logic        line_out,
    input logic        busy,
    input logic        frame_done,
    input logic        underrun
);
    // R1
    idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line_out);

    // R10
    ready_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> busy);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (!frame_done && !busy));

    // R6
    done_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!line_out && !pix_ready));

    // R8
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && busy) |=> underrun);

    // R2
    start_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && frame_len != 13'd0) |=> (busy && !underrun));

    // R2
    zero_len_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(start && frame_len != 13'd0)) |=> !busy);
endmodule

bind pixel_line_encoder ple_checker u_ple_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .frame_len  (frame_len),
    .pix_ready  (pix_ready),
    .line_out   (line_out),
    .busy       (busy),
    .frame_done (frame_done),
    .underrun   (underrun)
);

// File: tb/pixel_line_encoder_bench.sv
module pixel_line_encoder_bench;
    localparam int BMAX = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [12:0] frame_len = '0;
    logic [31:0] bit_timing = '0;
    logic [19:0] latch_gap = '0;
    logic [2:0]  color_mode = 3'd2;
    logic        pix_valid = 1'b0;
    logic [23:0] pix_data = '0;
    logic        pix_ready, line_out, busy, frame_done, underrun;

    int tests = 0;
    int fails = 0;
    int hi_run [0:199];
    int lo_run [0:199];
    int nbits;
    logic [23:0] px [0:7];

    always #2 clk = ~clk;

    pixel_line_encoder #(.MAX_PIX(BMAX)) u_pixel_line_encoder (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
        .bit_timing(bit_timing), .latch_gap(latch_gap), .color_mode(color_mode),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .line_out(line_out), .busy(busy), .frame_done(frame_done),
        .underrun(underrun)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] expect_word(input int m, input logic [23:0] p);
        logic [7:0] r, g, b;
        r = p[23:16]; g = p[15:8]; b = p[7:0];
        case (m)
            0: return {r, g, b};
            1: return {r, b, g};
            3: return {g, b, r};
            4: return {b, r, g};
            5: return {b, g, r};
            default: return {g, r, b};
        endcase
    endfunction

    function automatic int atleast1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [31:0] mk_timing(input int t1h, input int t1l,
                                              input int t0h, input int t0l);
        return (32'(t1h) << 21) | (32'(t1l) << 16) | (32'(t0h) << 6) | 32'(t0l);
    endfunction

    // Drive pixels and measure runs on the line until frame_done
    task automatic run_frame(input int npix, input int stall_at, input int stall_cyc,
                             input bit disturb);
        for (int k = 0; k < 200; k++) begin hi_run[k] = 0; lo_run[k] = 0; end
        nbits = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fork
            begin
                for (int i = 0; i < npix; i++) begin
                    if (i == stall_at) begin
                        pix_valid = 1'b0;
                        repeat (stall_cyc) @(negedge clk);
                    end
                    pix_valid = 1'b1;
                    pix_data  = px[i];
                    while (!pix_ready) @(negedge clk);
                    @(negedge clk);
                end
                pix_valid = 1'b0;
            end
            begin
                logic prev;
                int run;
                prev = 1'b0; run = 0;
                forever begin
                    if (frame_done) break;
                    if (line_out != prev) begin
                        if (prev) begin hi_run[nbits] = run; nbits++; end
                        else if (nbits > 0) lo_run[nbits-1] = run;
                        run = 0;
                        prev = line_out;
                    end
                    run++;
                    @(negedge clk);
                end
                if (!prev && nbits > 0) lo_run[nbits-1] = run;
            end
            begin
                if (disturb) begin
                    repeat (15) @(negedge clk);
                    bit_timing = mk_timing(1, 1, 1, 1);
                    color_mode = 3'd0;
                    latch_gap  = 20'd3;
                    frame_len  = 13'd1;
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                end
            end
        join
    endtask

    // Compare measured runs to values computed from the requirements
    task automatic check_frame(input string req, input int npix, input int mode,
                               input int t1h, input int t1l, input int t0h,
                               input int t0l, input int gap, input bit lows);
        int bad_hi, bad_lo, k, ehi, elo, lastlo;
        logic [23:0] w;
        logic b;
        bad_hi = -1; bad_lo = -1; lastlo = 0;
        check(nbits == npix * 24, req, "bit count", nbits, npix * 24);
        for (int i = 0; i < npix; i++) begin
            w = expect_word(mode, px[i]);
            for (int j = 0; j < 24; j++) begin
                k = i * 24 + j;
                b = w[23 - j];
                ehi = b ? atleast1(t1h) : atleast1(t0h);
                elo = b ? atleast1(t1l) : atleast1(t0l);
                if (hi_run[k] != ehi && bad_hi < 0) bad_hi = k;
                if (k < npix * 24 - 1) begin
                    if (lo_run[k] != elo && bad_lo < 0) bad_lo = k;
                end else lastlo = elo + atleast1(gap);
            end
        end
        check(bad_hi < 0, req, "high pulse widths (first bad bit index)", bad_hi, -1);
        if (lows) begin
            check(bad_lo < 0, req, "low pulse widths (first bad bit index)", bad_lo, -1);
            check(lo_run[npix*24-1] == lastlo, req, "last low plus gap",
                  lo_run[npix*24-1], lastlo);
        end
        check(frame_done == 1'b1, "R6", "frame_done at end", frame_done, 1);
        @(negedge clk);
        check(frame_done == 1'b0 && busy == 1'b0, "R6", "pulse one cycle, busy falls",
              {frame_done, busy}, 0);
    endtask

    task automatic test_reset;
        check(line_out == 0 && busy == 0 && pix_ready == 0 && frame_done == 0
              && underrun == 0, "R1", "outputs after reset",
              {line_out, busy, pix_ready, frame_done, underrun}, 0);
    endtask

    task automatic test_basic;
        px[0] = 24'hA5_3C_F0; px[1] = 24'h01_80_7E;
        bit_timing = mk_timing(6, 3, 2, 5); latch_gap = 20'd10;
        color_mode = 3'd2; frame_len = 13'd2;
        run_frame(2, -1, 0, 1'b0);
        check_frame("R4", 2, 2, 6, 3, 2, 5, 10, 1'b1);
        check(underrun == 0, "R8", "no underrun when fed", underrun, 0);
        check(pix_ready == 0, "R10", "ready low when idle", pix_ready, 0);
    endtask

    task automatic test_modes;
        px[0] = 24'hC3_5A_0F;
        bit_timing = mk_timing(3, 1, 1, 2); latch_gap = 20'd2; frame_len = 13'd1;
        for (int m = 0; m < 8; m++) begin
            color_mode = 3'(m);
            run_frame(1, -1, 0, 1'b0);
            check_frame("R3", 1, m, 3, 1, 1, 2, 2, 1'b1);
        end
    endtask

    task automatic test_zero_counts;
        px[0] = 24'hFF_00_81; px[1] = 24'h12_34_56;
        bit_timing = mk_timing(0, 0, 0, 0); latch_gap = 20'd0;
        color_mode = 3'd0; frame_len = 13'd2;
        run_frame(2, -1, 0, 1'b0);
        // zero highs give 1 cycle, so both bit values look alike; the
        // lows and the gap are checked through the widths
        check_frame("R5", 2, 0, 0, 0, 0, 0, 0, 1'b1);
    endtask

    task automatic test_zero_len;
        frame_len = 13'd0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        check(busy == 0 && line_out == 0 && pix_ready == 0, "R2",
              "zero-length start ignored", {busy, line_out, pix_ready}, 0);
    endtask

    task automatic test_clamp;
        for (int i = 0; i < BMAX; i++) px[i] = 24'h10_20_30 + 24'(i * 24'h0B_0705);
        bit_timing = mk_timing(2, 1, 1, 2); latch_gap = 20'd4;
        color_mode = 3'd5; frame_len = 13'd9;
        run_frame(BMAX, -1, 0, 1'b0);
        check_frame("R7", BMAX, 5, 2, 1, 1, 2, 4, 1'b1);
        pix_valid = 1'b1;
        repeat (3) @(negedge clk);
        check(pix_ready == 0 && busy == 0, "R7", "no extra pixel taken",
              {pix_ready, busy}, 0);
        pix_valid = 1'b0;
    endtask

    task automatic test_underrun;
        px[0] = 24'h96_69_11; px[1] = 24'hE1_1E_C0; px[2] = 24'h0F_F0_AA;
        bit_timing = mk_timing(4, 2, 1, 3); latch_gap = 20'd5;
        color_mode = 3'd3; frame_len = 13'd3;
        run_frame(3, 1, 300, 1'b0);
        check_frame("R8", 3, 3, 4, 2, 1, 3, 5, 1'b0);
        check(underrun == 1, "R8", "underrun flagged", underrun, 1);
        repeat (4) @(negedge clk);
        check(underrun == 1, "R8", "underrun held while idle", underrun, 1);
        frame_len = 13'd1;
        run_frame(1, -1, 0, 1'b0);
        check_frame("R8", 1, 3, 4, 2, 1, 3, 5, 1'b1);
        check(underrun == 0, "R8", "underrun cleared by new start", underrun, 0);
    endtask

    task automatic test_disturb;
        px[0] = 24'hF0_0F_33; px[1] = 24'h3C_C3_55;
        bit_timing = mk_timing(5, 2, 2, 4); latch_gap = 20'd6;
        color_mode = 3'd2; frame_len = 13'd2;
        run_frame(2, -1, 0, 1'b1);
        check_frame("R9", 2, 2, 5, 2, 2, 4, 6, 1'b1);
        repeat (4) @(negedge clk);
        check(busy == 0, "R2", "start while busy not remembered", busy, 0);
    endtask

    task automatic test_typical;
        px[0] = 24'h80_40_01;
        bit_timing = mk_timing(21, 7, 8, 20); latch_gap = 20'd7142;
        color_mode = 3'd2; frame_len = 13'd1;
        run_frame(1, -1, 0, 1'b0);
        check_frame("R4", 1, 2, 21, 7, 8, 20, 7142, 1'b1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_basic();
        test_modes();
        test_zero_counts();
        test_zero_len();
        test_clamp();
        test_underrun();
        test_disturb();
        test_typical();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule